// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight level-sensitive interrupt request lines from peripherals and presents a single interrupt output to a processor core. Each line has a pending flag, a mask flag and an 8-bit priority value. The output is raised whenever at least one unmasked line is pending and the core has not disabled interrupts. While the output is high, a vector output carries the number of the most urgent line plus a fixed base of 8.

When the core acknowledges, the winning line's pending flag is cleared. If other unmasked lines are still pending, the output stays high in the next cycle and now shows the next winner, so the core can go straight from one handler to the next.

Software uses a small byte-wide write port. It can set pending flags, which raises an interrupt exactly as a hardware request would. It can also clear pending flags, program the mask and program each line's priority. A read always returns the current pending flags.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset all pending flags are 0, all mask flags are 0 (every line enabled), every priority is 0xFF and `irq_o` is low.
- R2: While `irq_o` is high, `vec_o` equals the winning line number plus 8 (line 1 gives 9, line 7 gives 15); while `irq_o` is low, `vec_o` is 0.
- R3: Writing the mask register (address 2, bit n for line n, 1 = masked) stops line n from driving `irq_o` or being acknowledged, while its pending flag stays readable.
- R4: A write to address 0 sets the pending flag of every line whose data bit is 1, and `irq_o` rises after that edge if the line is unmasked. A write to address 1 clears the pending flag of every line whose data bit is 1.
- R5: The priority of line n is written at address 8+n. Among unmasked pending lines, the lowest priority value wins. On equal values the lowest line number wins.
- R6: While `core_dis_i` is high, `irq_o` is low and no pending flag is lost. When `core_dis_i` returns low, the output reflects the pending state again in the same cycle.
- R7: An `ack_i` in a cycle with `irq_o` high clears only the winner's pending flag at that edge. An `ack_i` while `irq_o` is low changes nothing.
- R8: If unmasked lines remain pending after an acknowledge, `irq_o` is high in the very next cycle with the next winner's vector.
- R9: A request line is passed through a two-flop synchronizer. Its pending flag is visible on `reg_rdata_o` after the third rising edge following the input going high. As long as the synchronized level stays high, the flag is set again on every edge.
- R10: `reg_rdata_o` always shows the current pending flags, bit n for line n, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 8 | Level-sensitive request lines, bit n is line n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current pending flags |
| core_dis_i | input | 1 | Core-side global interrupt disable |
| irq_o | output | 1 | Interrupt request toward the core |
| ack_i | input | 1 | Core acknowledge strobe |
| vec_o | output | 8 | Vector of the winning line |

## Verification
A corrupted pending or mask flag shows up on `reg_rdata_o` or `irq_o` right after the edge that stored it. Choosing the wrong winner shows up as a wrong `vec_o` in the cycle before the acknowledge. The sweeps drain all eight lines under several priority patterns, so a fault in ordering, tie breaking or acknowledge clearing changes the vector sequence within at most eight acknowledges. A broken chaining path shows as `irq_o` low in the cycle right after an acknowledge, while the readback still shows eligible lines pending.

// File: rtl/vic_pkg.sv
// Package: shared register offsets for the vectored interrupt controller.
// Assumes byte addressing on a narrow write port; offsets are fixed decode values.
package vic_pkg;
    localparam int unsigned OFS_PEND_SET  = 0;
    localparam int unsigned OFS_PEND_CLR  = 1;
    localparam int unsigned OFS_MASK      = 2;
    localparam int unsigned OFS_PRIO_BASE = 8;
endpackage

// File: rtl/vic_sync.sv
// Module: two-flop synchronizer, one chain per request line.
// Assumes requests are level signals held long enough to be seen by two edges.
module vic_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_chain
        logic stage1_q;
        logic stage2_q;
        // Purpose: move one request bit through two flops into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= async_i[g];
                stage2_q <= stage1_q;
            end
        end
        assign sync_o[g] = stage2_q;
    end
endmodule

// File: rtl/vic_regs.sv
// Module: pending, mask and priority storage with the software write decode.
// Assumes clear sources (software clear, acknowledge) win over set sources in one cycle.
module vic_regs
    import vic_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_W    = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    input  logic [NUM_LINES-1:0]              hw_set_i,
    input  logic [NUM_LINES-1:0]              ack_clr_i,
    output logic [NUM_LINES-1:0]              pend_o,
    output logic [NUM_LINES-1:0]              mask_o,
    output logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_o
);
    logic [NUM_LINES-1:0] sw_set;
    logic [NUM_LINES-1:0] sw_clr;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] mask_q;

    // Purpose: decode software set and clear strobes into per-line vectors.
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        if (wr_i && addr_i == ADDR_W'(OFS_PEND_SET)) sw_set = wdata_i[NUM_LINES-1:0];
        if (wr_i && addr_i == ADDR_W'(OFS_PEND_CLR)) sw_clr = wdata_i[NUM_LINES-1:0];
    end

    // Purpose: update pending flags; clears take precedence over sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | hw_set_i | sw_set) & ~sw_clr & ~ack_clr_i;
    end

    // Purpose: hold the per-line mask flags.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (wr_i && addr_i == ADDR_W'(OFS_MASK)) mask_q <= wdata_i[NUM_LINES-1:0];
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prio
        logic [PRIO_W-1:0] prio_q;
        // Purpose: hold one line's priority, reset to the least urgent value.
        always_ff @(posedge clk) begin
            if (!rst_n) prio_q <= '1;
            else if (wr_i && addr_i == ADDR_W'(OFS_PRIO_BASE + g)) prio_q <= wdata_i[PRIO_W-1:0];
        end
        assign prio_o[g] = prio_q;
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    // R4: a software clear leaves every named line non-pending after the edge.
    a_r4_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(OFS_PEND_CLR))
        |=> ((pend_q & $past(wdata_i[NUM_LINES-1:0])) == '0));
    // R7: at most one line is cleared by an acknowledge.
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr_i));
endmodule

// File: rtl/vic_arbiter.sv
// Module: picks the most urgent eligible line by priority value.
// Assumes lower values are more urgent and ties go to the lower line index.
module vic_arbiter #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_W    = 8,
    localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]              elig_i,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_i,
    output logic                              win_valid_o,
    output logic [IDX_W-1:0]                  win_idx_o
);
    logic [PRIO_W-1:0] best_prio;

    // Purpose: scan lines in ascending order, keeping a strictly better candidate only.
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        best_prio   = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig_i[i] && (!win_valid_o || prio_i[i] < best_prio)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                best_prio   = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: top of the vectored priority interrupt controller.
// Assumes the core samples vec_o in the cycle it raises ack_i; vectors are line plus VEC_BASE.
module vec_irq_ctrl #(
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned PRIO_W    = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned VEC_BASE  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [NUM_LINES-1:0] reg_rdata_o,
    input  logic                 core_dis_i,
    output logic                 irq_o,
    input  logic                 ack_i,
    output logic [VEC_W-1:0]     vec_o
);
    localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0]             hw_set;
    logic [NUM_LINES-1:0]             pend_q;
    logic [NUM_LINES-1:0]             mask_q;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_LINES-1:0]             eligible;
    logic [NUM_LINES-1:0]             ack_clr;
    logic                             win_valid;
    logic [IDX_W-1:0]                 win_idx;
    logic                             ack_fire;

    vic_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_req_i),
        .sync_o  (hw_set)
    );

    vic_regs #(
        .NUM_LINES (NUM_LINES),
        .PRIO_W    (PRIO_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .hw_set_i  (hw_set),
        .ack_clr_i (ack_clr),
        .pend_o    (pend_q),
        .mask_o    (mask_q),
        .prio_o    (prio_q)
    );

    assign eligible = pend_q & ~mask_q;

    vic_arbiter #(
        .NUM_LINES (NUM_LINES),
        .PRIO_W    (PRIO_W)
    ) u_arb (
        .elig_i      (eligible),
        .prio_i      (prio_q),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    // Purpose: drive the core request, the vector and the acknowledge clear.
    always_comb begin
        irq_o    = win_valid && !core_dis_i;
        ack_fire = ack_i && irq_o;
        ack_clr  = '0;
        if (ack_fire) ack_clr[win_idx] = 1'b1;
        vec_o    = irq_o ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;
    end

    assign reg_rdata_o = pend_q;

    // R3: a raised output always names a pending, unmasked line.
    a_r3_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q[win_idx] && !mask_q[win_idx]));
    // R2: the vector stays inside the window of line numbers plus the base.
    a_r2_vec_window: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o >= VEC_W'(VEC_BASE) && vec_o < VEC_W'(VEC_BASE + NUM_LINES)));
    // R6: while the core disables interrupts and no write occurs, no pending flag is lost.
    a_r6_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (core_dis_i && !reg_wr_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    // R7: the acknowledged line is not pending after the edge.
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> !pend_q[$past(win_idx)]);
    // R8: with other eligible lines left, the output is up again in the next cycle.
    a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && $countones(eligible) > 1 && !reg_wr_i) |=> (irq_o || core_dis_i));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req_i = '0;
    logic       reg_wr_i = 1'b0;
    logic [3:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       core_dis_i = 1'b0;
    logic       irq_o;
    logic       ack_i = 1'b0;
    logic [7:0] vec_o;

    int checks = 0;
    int errors = 0;
    bit m_pend[8];
    bit m_mask[8];
    int m_prio[8];

    always #4 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .core_dis_i(core_dis_i), .irq_o(irq_o), .ack_i(ack_i), .vec_o(vec_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        reg_wr_i = 1'b1; reg_addr_i = 4'(addr); reg_wdata_i = 8'(data);
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    function automatic int model_win();
        int w = -1;
        for (int i = 0; i < 8; i++)
            if (m_pend[i] && !m_mask[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
        return w;
    endfunction

    function automatic int model_pend();
        int v = 0;
        for (int i = 0; i < 8; i++) if (m_pend[i]) v |= (1 << i);
        return v;
    endfunction

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_mask[i] = 0; m_prio[i] = 255; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 irq after reset", int'(irq_o), 0);
        check("R1 pending after reset", int'(reg_rdata_o), 0);
        check("R2 vec idle", int'(vec_o), 0);

        // R4, R2, R7: each line raised by software alone
        for (int i = 0; i < 8; i++) begin
            wr(0, 1 << i);
            check("R4 sw set pending", int'(reg_rdata_o), 1 << i);
            check("R4 sw set irq", int'(irq_o), 1);
            check("R2 vector", int'(vec_o), i + 8);
            ack();
            check("R7 ack clears", int'(reg_rdata_o), 0);
            check("R7 irq drops", int'(irq_o), 0);
        end

        // R5, R8, R1: drain order under several priority patterns (k=0 uses reset 0xFF ties)
        for (int k = 0; k < 4; k++) begin
            if (k > 0)
                for (int i = 0; i < 8; i++) begin
                    m_prio[i] = (k == 3) ? 32 : ((i * 3 + k * 5) % 8) * 16;
                    wr(8 + i, m_prio[i]);
                end
            wr(0, 8'hFF);
            for (int i = 0; i < 8; i++) m_pend[i] = 1;
            for (int n = 0; n < 8; n++) begin
                int w;
                w = model_win();
                check("R5 irq up", int'(irq_o), 1);
                check("R5 priority order vector", int'(vec_o), w + 8);
                ack();
                m_pend[w] = 0;
                check("R8 chained irq", int'(irq_o), (n < 7) ? 1 : 0);
                check("R10 pending readback", int'(reg_rdata_o), model_pend());
            end
        end

        // R3: masked lines stay pending but silent
        wr(2, 8'hA5);
        for (int i = 0; i < 8; i++) m_mask[i] = ((8'hA5 >> i) & 1) != 0;
        wr(0, 8'hA5);
        for (int i = 0; i < 8; i++) if ((8'hA5 >> i) & 1) m_pend[i] = 1;
        check("R3 masked no irq", int'(irq_o), 0);
        check("R3 masked pending kept", int'(reg_rdata_o), 8'hA5);
        ack();
        check("R7 ack while idle ignored", int'(reg_rdata_o), 8'hA5);
        wr(0, 8'hFF);
        for (int i = 0; i < 8; i++) m_pend[i] = 1;
        for (int n = 0; n < 4; n++) begin
            int w;
            w = model_win();
            check("R3 only unmasked vector", int'(vec_o), w + 8);
            ack();
            m_pend[w] = 0;
        end
        check("R3 masked remain", int'(reg_rdata_o), 8'hA5);
        check("R3 irq low with only masked", int'(irq_o), 0);
        wr(2, 0);
        for (int i = 0; i < 8; i++) m_mask[i] = 0;
        wr(1, 8'hFF);
        for (int i = 0; i < 8; i++) m_pend[i] = 0;
        check("R4 sw clear", int'(reg_rdata_o), 0);

        // R6: global disable
        wr(0, 8'h10);
        core_dis_i = 1'b1;
        @(negedge clk);
        check("R6 irq suppressed", int'(irq_o), 0);
        check("R6 pending kept", int'(reg_rdata_o), 8'h10);
        ack();
        check("R7 ack while disabled ignored", int'(reg_rdata_o), 8'h10);
        core_dis_i = 1'b0;
        #1;
        check("R6 irq returns", int'(irq_o), 1);
        check("R6 vector after enable", int'(vec_o), 12);
        @(negedge clk);
        wr(1, 8'h10);
        check("R4 sw clear single", int'(reg_rdata_o), 0);

        // R9: hardware request through synchronizer
        irq_req_i = 8'h40;
        @(negedge clk);
        check("R9 not after 1 edge", int'(reg_rdata_o), 0);
        @(negedge clk);
        check("R9 not after 2 edges", int'(reg_rdata_o), 0);
        @(negedge clk);
        check("R9 pending after 3 edges", int'(reg_rdata_o), 8'h40);
        check("R9 vector", int'(vec_o), 14);
        ack();
        check("R7 ack clears hw line", int'(reg_rdata_o), 0);
        @(negedge clk);
        check("R9 level re-sets", int'(reg_rdata_o), 8'h40);
        irq_req_i = 8'h00;
        repeat (3) @(negedge clk);
        ack();
        check("R9 cleared after release", int'(reg_rdata_o), 0);
        check("R9 irq low after release", int'(irq_o), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule